// File: doc/BRIEF.md
# Sound CPU Interval Timer Bank

This block gives an 8-bit sound processor three interval timers. Each timer divides the 1.024 MHz processor clock down to a tick rate, counts ticks against a programmable 8-bit period, and bumps a small 4-bit event counter each time a full period has elapsed. Two of the timers tick every 128 clocks (8 kHz). The third ticks every 16 clocks (64 kHz). Software polls the event counters over a memory-mapped register bus. A counter read returns the count and clears it, so each poll returns the events since the previous poll.

Run/stop control for each timer arrives as one bit per timer from a control register that lives outside the block. Period registers and counters are decoded on the block's own write and read ports. All pins are plain control and register pins: the block has no streaming data path, so it has no valid/ready handshake. Reads are single-strobe. The result is registered and appears one clock after the strobe.

Top module: `snd_interval_timers`

## Requirements
- R1: While enabled, timers 0 and 1 each make one internal tick every 128 clocks and timer 2 one tick every 16 clocks. The first tick falls 128 (or 16) clocks after the clock edge at which the enable was first seen high.
- R2: Timer i's period register is written at address 0xFA+i, so timers 0, 1 and 2 use 0xFA, 0xFB and 0xFC. A period value of 0 acts as a period of 256.
- R3: On each tick the stage count advances by one. When the advanced value reaches the period, the stage count returns to 0 and the 4-bit event counter increments, wrapping from 15 to 0.
- R4: A read strobe at address 0xFD+i returns the counter of timer i on rd_data one clock later and clears that counter at the same edge. A wrap at that same edge leaves the counter at 1. With no strobe, or with a strobe at any other address, rd_data is 0 one clock later.
- R5: A write at address 0xFD+i clears timer i's counter. The written data is ignored.
- R6: While tmr_en[i] is 0, timer i makes no ticks. Its counter keeps its value except for clears.
- R7: On a 0-to-1 change of tmr_en[i], the stage count, the counter and the prescaler of timer i restart from zero.
- R8: Writing a period register with the value it already holds changes nothing.
- R9: A period write does not reset the stage count. The new period is used at the next tick's comparison, so a stage count already at or past the new period wraps at that tick.
- R10: Bits 7:4 of rd_data are always 0.
- R11: After reset all timers are stopped, all counters and stage counts are 0, and all periods act as 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock (1.024 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_en | input | 3 | Run bit per timer, from the shared control register |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Registered read data, valid one clock after rd_en |

## Verification
Read data and the read-clear both take effect at the edge that samples the strobe, so rd_data is due one clock after rd_en. The bench compares it at the following falling edge against a behavioural model stepped at every rising edge. A timer's counter step is due at the edge that completes divisor × period clocks after its enable edge. A period or counter write takes effect at the edge that samples it. The hand-derived checks place their reads in the middle of a tick interval, so an off-by-one in any of these latencies changes the value read, and the every-cycle model comparison catches the rest.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int          NUM_TIMERS     = 3;
  localparam int          BUS_AW         = 8;
  localparam int          BUS_DW         = 8;
  localparam int          EVT_W          = 4;
  localparam int          DIV_SLOW       = 128;
  localparam int          DIV_FAST       = 16;
  localparam logic [7:0]  PERIOD_ADDR0   = 8'hFA;
  localparam logic [7:0]  COUNT_ADDR0    = 8'hFD;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int DIV = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase_q;

  assign tick = run && !restart && (phase_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 phase_q <= '0;
    else if (restart)           phase_q <= '0;
    else if (run)               phase_q <= (phase_q == LAST) ? '0 : phase_q + PW'(1);
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R1

  AST_RESTART_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick); // R7
endmodule

// File: rtl/tmr_stage_cnt.sv
module tmr_stage_cnt #(
  parameter int STAGE_W = 8,
  parameter int CNT_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               tick,
  input  logic               clr,
  input  logic [STAGE_W-1:0] period_raw,
  output logic [CNT_W-1:0]   cnt_o
);
  localparam int SUM_W = STAGE_W + 1;

  logic [STAGE_W-1:0] stage_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [SUM_W-1:0]   limit;
  logic [SUM_W-1:0]   next_stage;
  logic               wrap;

  always_comb begin
    limit      = (period_raw == '0) ? (SUM_W'(1) << STAGE_W) : {1'b0, period_raw};
    next_stage = {1'b0, stage_q} + SUM_W'(1);
    wrap       = tick && (next_stage >= limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else if (restart) begin
      stage_q <= '0;
    end else if (tick) begin
      stage_q <= wrap ? '0 : next_stage[STAGE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (restart)   cnt_q <= '0;
    else if (clr)       cnt_q <= CNT_W'(wrap);
    else if (wrap)      cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !clr) |=> (cnt_q == $past(cnt_q) || cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1)))); // R3

  AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !restart && !tick) |=> (cnt_q == '0)); // R5

  AST_IDLE_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(stage_q)); // R6
endmodule

// File: rtl/snd_interval_timers.sv
module snd_interval_timers #(
  parameter int                          N_TMR     = tmr_pkg::NUM_TIMERS,
  parameter int                          AW        = tmr_pkg::BUS_AW,
  parameter int                          DW        = tmr_pkg::BUS_DW,
  parameter int                          CW        = tmr_pkg::EVT_W,
  parameter int                          SLOW_DIV  = tmr_pkg::DIV_SLOW,
  parameter int                          FAST_DIV  = tmr_pkg::DIV_FAST,
  parameter logic [N_TMR-1:0]            FAST_MASK = N_TMR'(1) << (N_TMR - 1),
  parameter logic [AW-1:0]               PER_BASE  = AW'(tmr_pkg::PERIOD_ADDR0),
  parameter logic [AW-1:0]               CNT_BASE  = AW'(tmr_pkg::COUNT_ADDR0)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_TMR-1:0] tmr_en,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data
);
  localparam int PAD_W = DW - CW;

  logic [N_TMR-1:0] en_q;
  logic [N_TMR-1:0] rise;
  logic [N_TMR-1:0] tick;
  logic [N_TMR-1:0] clr;
  logic [N_TMR-1:0] rd_hit;
  logic [DW-1:0]    per_q [N_TMR];
  logic [CW-1:0]    cnt   [N_TMR];
  logic [DW-1:0]    rd_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= tmr_en;
  end

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    localparam int DIV_G = FAST_MASK[g] ? FAST_DIV : SLOW_DIV;
    localparam logic [AW-1:0] PER_ADDR = PER_BASE + AW'(g);
    localparam logic [AW-1:0] CNT_ADDR = CNT_BASE + AW'(g);

    assign rise[g]   = tmr_en[g] && !en_q[g];
    assign rd_hit[g] = rd_en && (rd_addr == CNT_ADDR);
    assign clr[g]    = rd_hit[g] || (wr_en && (wr_addr == CNT_ADDR));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             per_q[g] <= '0;
      else if (wr_en && wr_addr == PER_ADDR)  per_q[g] <= wr_data;
    end

    tmr_prescaler #(.DIV(DIV_G)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (tmr_en[g]),
      .restart (rise[g]),
      .tick    (tick[g])
    );

    tmr_stage_cnt #(.STAGE_W(DW), .CNT_W(CW)) u_stage (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (rise[g]),
      .tick       (tick[g]),
      .clr        (clr[g]),
      .period_raw (per_q[g]),
      .cnt_o      (cnt[g])
    );

    AST_RISE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      rise[g] |=> (cnt[g] == '0)); // R7

    AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!tmr_en[g] && !clr[g]) |=> (cnt[g] == $past(cnt[g]))); // R6

    AST_OFF_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !tmr_en[g] |-> !tick[g]); // R6
  end

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < N_TMR; i++) begin
      if (rd_hit[i]) rd_next = {{PAD_W{1'b0}}, cnt[i]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_next;
  end

  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rd_data == '0)); // R4

  AST_RD_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (rd_data[DW-1:CW] == '0)); // R10

  AST_ONE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> $onehot0(rd_hit)); // R4
endmodule

// File: tb/sim_snd_interval_timers.sv
module sim_snd_interval_timers;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] tmr_en = 3'b000;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = 8'h00;
  logic [7:0] wr_data = 8'h00;
  logic       rd_en = 1'b0;
  logic [7:0] rd_addr = 8'h00;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  snd_interval_timers u0 (
    .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // behavioural reference model, stepped at every rising edge
  int m_phase [3];
  int m_stage [3];
  int m_cnt   [3];
  int m_per   [3];
  int m_enq   [3];
  int m_rd = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        m_phase[i] = 0; m_stage[i] = 0; m_cnt[i] = 0; m_per[i] = 0; m_enq[i] = 0;
      end
      m_rd = 0;
    end else begin
      int nrd;
      nrd = 0;
      for (int i = 0; i < 3; i++) begin
        int div, lim, tk, wrp, clr;
        div = (i == 2) ? 16 : 128;
        lim = (m_per[i] == 0) ? 256 : m_per[i];
        tk = 0; wrp = 0;
        clr = ((rd_en && int'(rd_addr) == 253 + i) || (wr_en && int'(wr_addr) == 253 + i)) ? 1 : 0;
        if (rd_en && int'(rd_addr) == 253 + i) nrd = m_cnt[i];
        if (tmr_en[i] && m_enq[i] == 0) begin
          m_phase[i] = 0; m_stage[i] = 0; m_cnt[i] = 0;
        end else begin
          if (tmr_en[i]) begin
            if (m_phase[i] == div - 1) begin m_phase[i] = 0; tk = 1; end
            else m_phase[i] = m_phase[i] + 1;
          end
          if (tk == 1) begin
            if (m_stage[i] + 1 >= lim) begin m_stage[i] = 0; wrp = 1; end
            else m_stage[i] = m_stage[i] + 1;
          end
          if (clr == 1) m_cnt[i] = wrp;
          else          m_cnt[i] = (m_cnt[i] + wrp) % 16;
        end
        m_enq[i] = tmr_en[i] ? 1 : 0;
        if (wr_en && int'(wr_addr) == 250 + i) m_per[i] = int'(wr_data);
      end
      m_rd = nrd;
    end
  end

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  // every falling edge: registered read data against the model (R4)
  always @(negedge clk) begin
    if (!done) check("R4 model", int'(rd_data), m_rd);
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_at(logic [7:0] a, string tag, int exp);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    check(tag, int'(rd_data), exp);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      done = 1'b1;
      summary();
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    // R11: counters read zero after reset
    rd_at(8'hFD, "R11 cnt0", 0);
    rd_at(8'hFE, "R11 cnt1", 0);
    rd_at(8'hFF, "R11 cnt2", 0);
    // R2/R11: default period acts as 256 (timer 2: 256 ticks of 16 clocks)
    tmr_en = 3'b100; wait_cyc(4100);
    rd_at(8'hFF, "R2 default period 256", 1);
    tmr_en = 3'b000; wait_cyc(1);
    // R2: explicit zero also means 256 -> still 0 after 250 clocks
    wr(8'hFC, 8'h00);
    tmr_en = 3'b100; wait_cyc(250);
    rd_at(8'hFF, "R2 zero period", 0);
    tmr_en = 3'b000; wait_cyc(1);
    // R1: fast timer, period 3 -> event every 48 clocks
    wr(8'hFC, 8'd3);
    tmr_en = 3'b100; wait_cyc(250);
    rd_at(8'hFF, "R1 fast rate", 5);
    tmr_en = 3'b000; wait_cyc(1);
    // R1: slow timers
    wr(8'hFA, 8'd2);
    tmr_en = 3'b001; wait_cyc(600);
    rd_at(8'hFD, "R1 slow timer0", 2);
    tmr_en = 3'b000; wait_cyc(1);
    wr(8'hFB, 8'd1);
    tmr_en = 3'b010; wait_cyc(300);
    rd_at(8'hFE, "R1 slow timer1", 2);
    tmr_en = 3'b000; wait_cyc(1);
    // R3: counter wraps 15 -> 0 (17 events read as 1)
    wr(8'hFC, 8'd1);
    tmr_en = 3'b100; wait_cyc(277);
    rd_at(8'hFF, "R3 wrap", 1);
    tmr_en = 3'b000; wait_cyc(1);
    // R10: count 15 reads as 0x0F with upper nibble zero
    tmr_en = 3'b100; wait_cyc(245);
    rd_at(8'hFF, "R10 upper bits", 15);
    rd_at(8'hFF, "R4 read clears", 0);
    rd_at(8'hF8, "R4 other address", 0);
    // R6: disabled timer holds its count
    wait_cyc(40);
    tmr_en = 3'b000; wait_cyc(100);
    rd_at(8'hFF, "R6 disabled hold", 2);
    // R7: re-enable clears a non-zero count
    tmr_en = 3'b010; wait_cyc(300);
    tmr_en = 3'b000; wait_cyc(1);
    tmr_en = 3'b010; wait_cyc(5);
    rd_at(8'hFE, "R7 enable restart", 0);
    tmr_en = 3'b000; wait_cyc(1);
    // R5: write to counter clears it, data ignored
    tmr_en = 3'b001; wait_cyc(600);
    wr(8'hFD, 8'hA5);
    rd_at(8'hFD, "R5 write clear", 0);
    rd_at(8'hFA, "R5 period untouched reads zero", 0);
    tmr_en = 3'b000; wait_cyc(1);
    // R8: rewriting the same period keeps the stage count
    wr(8'hFC, 8'd5);
    tmr_en = 3'b100; wait_cyc(50);
    wr(8'hFC, 8'd5);
    wait_cyc(40);
    rd_at(8'hFF, "R8 same period rewrite", 1);
    tmr_en = 3'b000; wait_cyc(1);
    // R9: lowering the period below the stage wraps at the next tick
    wr(8'hFC, 8'd10);
    tmr_en = 3'b100; wait_cyc(133);
    wr(8'hFC, 8'd3);
    wait_cyc(20);
    rd_at(8'hFF, "R9 new period next compare", 1);
    tmr_en = 3'b000; wait_cyc(3);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule